// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor. Five peripheral sources raise one-cycle request pulses. Each pulse latches into a pending-flag register. A separate mask register decides which latched flags may interrupt the processor. A global master enable gates the whole scheme. The processor sets the master enable with an "enable interrupts" instruction, and the enable takes effect only after one further instruction has retired. The processor clears it with a "disable interrupts" instruction.

At each instruction boundary the processor looks at `take_o`. When `take_o` is high, `vector_o` holds the handler address of the most urgent unmasked source. The processor answers with `ack_i`, pushes its own return address and jumps to the vector. On that acknowledge the controller does three things: it clears the winning flag, drops the master enable, and holds a service window for the fixed length of the interrupt entry sequence. Both registers can be read and written over a simple byte-wide register bus.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset:
  - the flag register reads 0xE0 and the mask register reads 0x00;
  - the master enable is clear;
  - `take_o` and `svc_busy_o` are low.
- R2: A source is pending when its flag bit and its mask bit are both 1. `take_o` is high exactly when the master enable is set, at least one source is pending, and no service window is open.
- R3: The pending source with the lowest bit number wins. Bit 0 is vertical blank, bit 1 display status, bit 2 timer, bit 3 serial and bit 4 joypad. `vector_o` equals 0x40 + 8 × (winning bit number), so bits 0 to 4 give 0x40, 0x48, 0x50, 0x58 and 0x60. With nothing pending, `vector_o` is 0x0000.
- R4: An acknowledge accepted while `take_o` is high has these effects:
  - it clears only the winning flag bit; other pending flags stay set;
  - it clears the master enable from the next cycle on.
- R5: An `ei_i` pulse arms the master enable. The enable becomes set on the first `insn_done_i` seen in a later cycle than the `ei_i` pulse. An `insn_done_i` in the same cycle as `ei_i` does not count.
- R6: `di_i` clears the master enable and cancels an armed `ei_i`. When `di_i` and `ei_i` arrive in the same cycle, `di_i` wins.
- R7: Flag register bits 7:5 always read as 1, and writes to them have no effect.
- R8: A source pulse in the same cycle as a bus write to the flag register leaves that source's bit set.
- R9: After an accepted acknowledge, `svc_busy_o` is high for exactly 5 cycles.
- R10: `ack_i` while `take_o` is low changes no flag and has no other effect.
- R11: The flag register sits at address 0xFF0F and the mask register at 0xFFFF. Reading any other address returns 0x00, and writing any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 5 | Source request pulses, bit n = source n |
| bus_addr_i | input | 16 | Register bus address |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Register bus read data (combinational) |
| ei_i | input | 1 | Enable-interrupts instruction executed |
| di_i | input | 1 | Disable-interrupts instruction executed |
| insn_done_i | input | 1 | Instruction retired this cycle |
| take_o | output | 1 | Interrupt entry requested |
| vector_o | output | 16 | Handler address of the winning source |
| ack_i | input | 1 | Processor begins interrupt entry |
| svc_busy_o | output | 1 | Interrupt entry sequence in progress |

## Verification
The assertions check these properties on every cycle:
- a source pulse always lands in its flag bit, whatever bus write arrives alongside it;
- an accepted acknowledge removes exactly one flag and drops the master enable;
- a rising master enable is always preceded by a retirement that was not the enabling instruction;
- the winner is always the lowest pending bit;
- the upper flag bits always read as ones.

Some behaviours only the bench's scenarios can show:
- the full one-instruction delay across separate cycles;
- a disable that cancels an armed enable;
- an acknowledge ignored while nothing may be taken;
- the exact length of the service window;
- each of the five vector values.

// File: rtl/vec_irq_pkg.sv
`timescale 1ns/1ps
package vec_irq_pkg;
   localparam int unsigned BUS_AW = 16;
   localparam int unsigned BUS_DW = 8;
   typedef logic [BUS_AW-1:0] bus_addr_t;
   typedef logic [BUS_DW-1:0] bus_data_t;
endpackage

// File: rtl/vec_irq_flag_bank.sv
`timescale 1ns/1ps
module vec_irq_flag_bank
   import vec_irq_pkg::*;
#(
   parameter int unsigned NSRC      = 5,
   parameter bus_addr_t   FLAG_ADDR = 16'hFF0F,
   parameter bus_addr_t   MASK_ADDR = 16'hFFFF
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] src_i,
   input  logic [NSRC-1:0] clr_i,
   input  bus_addr_t       addr_i,
   input  logic            we_i,
   input  bus_data_t       wdata_i,
   output bus_data_t       rdata_o,
   output logic [NSRC-1:0] flag_o,
   output logic [NSRC-1:0] mask_o
);
   localparam int unsigned PAD = BUS_DW - NSRC;

   logic      wr_flag, wr_mask;
   bus_data_t mask_q;
   bus_data_t flag_rd;

   assign wr_flag = we_i && (addr_i == FLAG_ADDR);
   assign wr_mask = we_i && (addr_i == MASK_ADDR);

   for (genvar i = 0; i < NSRC; i++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)          flag_o[i] <= 1'b0;
         else if (src_i[i])    flag_o[i] <= 1'b1;
         else if (wr_flag)     flag_o[i] <= wdata_i[i];
         else if (clr_i[i])    flag_o[i] <= 1'b0;
      end

      AST_SRC_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         src_i[i] |=> flag_o[i]); // R8
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mask_q <= '0;
      else if (wr_mask) mask_q <= wdata_i;
   end
   assign mask_o = mask_q[NSRC-1:0];

   if (PAD > 0) begin : g_pad
      assign flag_rd = {{PAD{1'b1}}, flag_o};
   end else begin : g_nopad
      assign flag_rd = flag_o;
   end

   always_comb begin
      if (addr_i == FLAG_ADDR)      rdata_o = flag_rd;
      else if (addr_i == MASK_ADDR) rdata_o = mask_q;
      else                          rdata_o = '0;
   end

   AST_HI_BITS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == FLAG_ADDR) |-> (rdata_o[BUS_DW-1:NSRC] == '1)); // R7
endmodule

// File: rtl/vec_irq_prio_enc.sv
`timescale 1ns/1ps
module vec_irq_prio_enc #(
   parameter int unsigned NSRC     = 5,
   parameter int unsigned VW       = 16,
   parameter int unsigned VEC_BASE = 'h40,
   parameter int unsigned VEC_STEP = 8
) (
   input  logic [NSRC-1:0] req_i,
   output logic            any_o,
   output logic [NSRC-1:0] win_oh_o,
   output logic [VW-1:0]   vec_o
);
   localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

   logic [IDXW-1:0] idx;

   always_comb begin
      idx = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req_i[i]) idx = IDXW'(i);
      end
   end

   assign any_o    = |req_i;
   assign win_oh_o = any_o ? (NSRC'(1) << idx) : '0;
   assign vec_o    = any_o ? VW'(VEC_BASE + int'(idx) * VEC_STEP) : '0;
endmodule

// File: rtl/vec_irq_master_en.sv
`timescale 1ns/1ps
module vec_irq_master_en #(
   parameter int unsigned SVC_CYC = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ei_i,
   input  logic di_i,
   input  logic done_i,
   input  logic ack_i,
   output logic ime_o,
   output logic busy_o
);
   localparam int unsigned CW = $clog2(SVC_CYC + 1);

   logic          armed_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ime_o   <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (ack_i || di_i)                  ime_o <= 1'b0;
         else if (done_i && armed_q && !ei_i) ime_o <= 1'b1;

         if (di_i)                armed_q <= 1'b0;
         else if (ei_i)           armed_q <= 1'b1;
         else if (done_i)         armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (ack_i)         cnt_q <= CW'(SVC_CYC);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end
   assign busy_o = (cnt_q != '0);

   AST_EI_DELAYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ime_o) |-> ($past(done_i) && !$past(ei_i))); // R5
   AST_DI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      di_i |=> !ime_o); // R6
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl
   import vec_irq_pkg::*;
#(
   parameter int unsigned NSRC      = 5,
   parameter int unsigned VW        = 16,
   parameter int unsigned VEC_BASE  = 'h40,
   parameter int unsigned VEC_STEP  = 8,
   parameter int unsigned SVC_CYC   = 5,
   parameter bus_addr_t   FLAG_ADDR = 16'hFF0F,
   parameter bus_addr_t   MASK_ADDR = 16'hFFFF
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] src_req_i,
   input  logic [15:0]     bus_addr_i,
   input  logic            bus_we_i,
   input  logic [7:0]      bus_wdata_i,
   output logic [7:0]      bus_rdata_o,
   input  logic            ei_i,
   input  logic            di_i,
   input  logic            insn_done_i,
   output logic            take_o,
   output logic [VW-1:0]   vector_o,
   input  logic            ack_i,
   output logic            svc_busy_o
);
   if (NSRC < 1 || NSRC > BUS_DW) begin : g_bad_nsrc
      $error("NSRC must lie in 1..BUS_DW");
   end
   if (SVC_CYC < 1) begin : g_bad_svc
      $error("SVC_CYC must be at least 1");
   end
   if (VEC_STEP < 1 || VW < 8) begin : g_bad_vec
      $error("vector geometry out of range");
   end

   logic [NSRC-1:0] flag, mask, pend, win_oh, clr;
   logic            any_pend, ime, ack_fire, wr_flag;

   vec_irq_flag_bank #(
      .NSRC(NSRC), .FLAG_ADDR(FLAG_ADDR), .MASK_ADDR(MASK_ADDR)
   ) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_req_i), .clr_i(clr),
      .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
      .rdata_o(bus_rdata_o), .flag_o(flag), .mask_o(mask)
   );

   assign pend = flag & mask;

   vec_irq_prio_enc #(
      .NSRC(NSRC), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
   ) u_enc (
      .req_i(pend), .any_o(any_pend), .win_oh_o(win_oh), .vec_o(vector_o)
   );

   vec_irq_master_en #(.SVC_CYC(SVC_CYC)) u_men (
      .clk_i(clk_i), .rst_ni(rst_ni), .ei_i(ei_i), .di_i(di_i),
      .done_i(insn_done_i), .ack_i(ack_fire), .ime_o(ime), .busy_o(svc_busy_o)
   );

   assign take_o   = ime && any_pend && !svc_busy_o;
   assign ack_fire = ack_i && take_o;
   assign clr      = ack_fire ? win_oh : '0;
   assign wr_flag  = bus_we_i && (bus_addr_i == FLAG_ADDR);

   AST_TAKE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> (ime && !svc_busy_o && (pend != '0))); // R2
   AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_pend |-> ($onehot(win_oh) && ((win_oh & pend) == win_oh)
                    && (((win_oh - 1'b1) & pend) == '0))); // R3
   AST_ACK_DROPS_IME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_fire |=> (!ime && svc_busy_o)); // R4
   AST_ONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_fire && !wr_flag && (src_req_i == '0))
         |=> ($countones(flag) == $past($countones(flag)) - 1)); // R4
   AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !take_o && !wr_flag && (src_req_i == '0)) |=> $stable(flag)); // R10
endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  src = '0;
   logic [15:0] addr = 16'h0000;
   logic        we = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        ei = 1'b0, di = 1'b0, done = 1'b0, ack = 1'b0;
   logic        take, busy;
   logic [15:0] vec;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   vec_irq_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .src_req_i(src), .bus_addr_i(addr),
      .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .ei_i(ei), .di_i(di), .insn_done_i(done), .take_o(take),
      .vector_o(vec), .ack_i(ack), .svc_busy_o(busy)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [4:0] m_flag;
   logic [7:0] m_mask;
   bit         m_ime, m_arm;
   int         m_cnt;

   function automatic int m_low(input logic [4:0] p);
      for (int i = 0; i < 5; i++) if (p[i]) return i;
      return -1;
   endfunction
   function automatic bit m_take();
      return m_ime && ((m_flag & m_mask[4:0]) != 0) && (m_cnt == 0);
   endfunction
   function automatic logic [15:0] m_vec();
      int w = m_low(m_flag & m_mask[4:0]);
      return (w < 0) ? 16'h0000 : 16'(16'h40 + 8 * w);
   endfunction
   function automatic logic [7:0] m_rd(input logic [15:0] a);
      if (a == 16'hFF0F) return {3'b111, m_flag};
      if (a == 16'hFFFF) return m_mask;
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flag = '0; m_mask = '0; m_ime = 0; m_arm = 0; m_cnt = 0;
      end else begin
         bit acc;
         logic [4:0] nf;
         bit old_arm;
         acc = ack && m_take();
         nf = m_flag;
         if (we && addr == 16'hFF0F) nf = wdata[4:0];
         else if (acc) nf[m_low(m_flag & m_mask[4:0])] = 1'b0;
         nf = nf | src;
         if (we && addr == 16'hFFFF) m_mask = wdata;
         m_flag = nf;
         old_arm = m_arm;
         if (acc || di) m_ime = 0;
         else if (done && old_arm && !ei) m_ime = 1;
         if (di) m_arm = 0;
         else if (ei) m_arm = 1;
         else if (done) m_arm = 0;
         if (acc) m_cnt = 5;
         else if (m_cnt > 0) m_cnt--;
      end
      #1;
      if (rst_n && !finished) begin
         chk("R2", "take_o vs model", 32'(take), 32'(m_take()));
         chk("R3", "vector_o vs model", 32'(vec), 32'(m_vec()));
         chk("R9", "svc_busy_o vs model", 32'(busy), 32'(m_cnt != 0));
         chk("R11", "bus_rdata_o vs model", 32'(rdata), 32'(m_rd(addr)));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic drive(input logic [15:0] a, input logic w, input logic [7:0] d,
                        input logic [4:0] s, input logic e, input logic dd,
                        input logic dn, input logic k);
      @(negedge clk);
      addr = a; we = w; wdata = d; src = s; ei = e; di = dd; done = dn; ack = k;
      @(negedge clk);
      we = 0; wdata = '0; src = '0; ei = 0; di = 0; done = 0; ack = 0;
   endtask
   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      drive(a, 1'b1, d, 5'h00, 0, 0, 0, 0);
   endtask
   task automatic ctl(input logic e, input logic dd, input logic dn, input logic k);
      drive(16'h0000, 1'b0, 8'h00, 5'h00, e, dd, dn, k);
   endtask
   task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
      addr = a;
      #1;
      chk(req, $sformatf("read %04h", a), 32'(rdata), 32'(exp));
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      rd_chk("R1", 16'hFF0F, 8'hE0);
      rd_chk("R1", 16'hFFFF, 8'h00);
      chk("R1", "take_o", 32'(take), 0);
      chk("R1", "svc_busy_o", 32'(busy), 0);

      wr(16'hFFFF, 8'h1F);
      rd_chk("R11", 16'hFFFF, 8'h1F);
      wr(16'hFF0F, 8'hFF);
      rd_chk("R11", 16'hFF0F, 8'hFF);
      chk("R2", "take_o with master enable clear", 32'(take), 0);
      chk("R3", "vector all pending", 32'(vec), 32'h40);
      wr(16'hFF0F, 8'h00);
      rd_chk("R7", 16'hFF0F, 8'hE0);
      wr(16'hFF0F, 8'h1C);
      chk("R3", "vector bits 2..4", 32'(vec), 32'h50);

      ctl(1, 0, 1, 0);
      chk("R5", "take_o after ei+own done", 32'(take), 0);
      ctl(0, 0, 1, 0);
      chk("R5", "take_o after next done", 32'(take), 1);
      chk("R3", "vector timer", 32'(vec), 32'h50);

      ctl(0, 0, 0, 1);
      rd_chk("R4", 16'hFF0F, 8'hF8);
      chk("R4", "take_o after ack", 32'(take), 0);
      chk("R9", "busy after ack", 32'(busy), 1);
      idle(4);
      chk("R9", "busy 5th cycle", 32'(busy), 1);
      idle(1);
      chk("R9", "busy closed", 32'(busy), 0);

      ctl(1, 0, 0, 0);
      ctl(0, 0, 1, 0);
      chk("R5", "take_o re-enabled", 32'(take), 1);
      chk("R3", "vector serial", 32'(vec), 32'h58);
      ctl(0, 1, 0, 0);
      chk("R6", "di clears enable", 32'(take), 0);
      ctl(1, 0, 0, 0);
      ctl(0, 1, 0, 0);
      ctl(0, 0, 1, 0);
      chk("R6", "di cancels armed ei", 32'(take), 0);
      ctl(1, 1, 0, 0);
      ctl(0, 0, 1, 0);
      chk("R6", "di beats ei same cycle", 32'(take), 0);

      ctl(0, 0, 0, 1);
      rd_chk("R10", 16'hFF0F, 8'hF8);
      chk("R10", "busy after ignored ack", 32'(busy), 0);

      drive(16'hFF0F, 1'b1, 8'h00, 5'h02, 0, 0, 0, 0);
      rd_chk("R8", 16'hFF0F, 8'hE2);

      for (int b = 0; b < 5; b++) begin
         wr(16'hFF0F, 8'(1 << b));
         chk("R3", $sformatf("vector bit %0d", b), 32'(vec), 32'(16'h40 + 8 * b));
      end
      wr(16'hFF0F, 8'h00);
      chk("R3", "vector none pending", 32'(vec), 0);

      wr(16'hFF0F, 8'h11);
      ctl(1, 0, 0, 0);
      ctl(0, 0, 1, 0);
      chk("R4", "take_o two pending", 32'(take), 1);
      chk("R3", "vector bit0 over bit4", 32'(vec), 32'h40);
      ctl(0, 0, 0, 1);
      rd_chk("R4", 16'hFF0F, 8'hF0);
      chk("R3", "vector joypad remains", 32'(vec), 32'h60);
      idle(5);
      ctl(1, 0, 0, 0);
      ctl(0, 0, 1, 0);
      chk("R4", "remaining source taken later", 32'(take), 1);
      ctl(0, 0, 0, 1);
      rd_chk("R4", 16'hFF0F, 8'hE0);
      idle(5);

      wr(16'hFFFF, 8'h00);
      wr(16'hFF10, 8'hFF);
      rd_chk("R11", 16'hFF0F, 8'hE0);
      rd_chk("R11", 16'hFFFF, 8'h00);
      rd_chk("R11", 16'hFF10, 8'h00);

      wr(16'hFFFF, 8'h1D);
      ctl(1, 0, 0, 0);
      ctl(0, 0, 1, 0);
      drive(16'h0000, 1'b0, 8'h00, 5'h02, 0, 0, 0, 0);
      rd_chk("R2", 16'hFF0F, 8'hE2);
      chk("R2", "masked source not taken", 32'(take), 0);
      drive(16'h0000, 1'b0, 8'h00, 5'h08, 0, 0, 0, 0);
      chk("R2", "unmasked source taken", 32'(take), 1);
      chk("R3", "vector skips masked bit", 32'(vec), 32'h58);

      idle(2);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule